// File: doc/BRIEF.md
# CCD Frame Line Sequencer

This block tracks the readout of one frame from a frame-transfer area sensor line by line. The frame is started by a start-of-frame pulse. After that, every end-of-line strobe from the line readout logic marks one memory-zone line transfer. The sequencer keeps an output-line index and labels each line with a region code. Downstream logic uses that code to tell the two dummy lines, the dark-reference bands, the isolation bands and the useful image lines apart. The dark bands are kept separate from the useful lines so that later stages can use them for dark clamping or smear correction.

The sequencer also issues a one-cycle line-transfer request to the memory-zone clock generator each time another transfer is needed. It raises a one-cycle frame-done pulse once the closing dummy line has been read.

In 2x2 binned mode, each output line sums two memory lines. The useful band therefore holds half as many output lines, and the index counts output lines, not transfers. All region sizes are parameters. The interface is made of plain control pulses and status levels. There is no back-pressure: a strobe is taken in the cycle it arrives.

Top module: `line_seq`

## Requirements
- R1: After reset, in_frame, line_idx, region, first_line, last_line, frame_done and xfer_req are all 0.
- R2: A sof pulse starts a frame. One cycle later, in_frame=1, line_idx=0, region=0 (dummy), first_line=1 and xfer_req=1 for one cycle.
- R3: In normal mode, each eol during a frame advances line_idx by one. The region codes by index (default sizes) are: 0 → code 0 (dummy); 1..12 → code 1 (top dark); 13..15 → code 2 (top isolation); 16..1039 → code 3 (useful); 1040..1042 → code 4 (bottom isolation); 1043..1054 → code 5 (bottom dark); 1055 → code 0 (dummy). A frame is 1056 lines.
- R4: In binned mode, line_idx advances only on every second eol. The useful band is 512 lines (indices 16..527). The bands after it shift to match, and the frame is 544 output lines.
- R5: first_line is 1 only at index 0, and last_line is 1 only at the final index of the frame. Both are 0 outside a frame.
- R6: The eol that completes the final line returns line_idx to 0 and clears in_frame. frame_done is 1 in the following cycle only.
- R7: An eol that arrives outside a frame has no effect: line_idx, in_frame and xfer_req stay 0.
- R8: A sof pulse during a frame restarts it at index 0. A sof in the same cycle as an eol takes priority over the eol.
- R9: Within a frame, every eol except the one completing the frame is followed, one cycle later, by a one-cycle xfer_req.
- R10: The binned input is sampled only when sof arrives. Changing it during a frame does not alter that frame's map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof | input | 1 | Start-of-frame pulse |
| eol | input | 1 | End-of-line strobe, one per memory line transfer |
| binned | input | 1 | 2x2 binned mode select, sampled at sof |
| line_idx | output | 11 | Current output-line index |
| region | output | 3 | Region code of the current line |
| first_line | output | 1 | Current line is the first of the frame |
| last_line | output | 1 | Current line is the last of the frame |
| in_frame | output | 1 | A frame is being read |
| frame_done | output | 1 | One-cycle pulse after the final line completes |
| xfer_req | output | 1 | One-cycle request for the next line transfer |

## Verification
Every result follows its stimulus by exactly one clock edge. line_idx, in_frame, frame_done and xfer_req are registered, and region and the flags are decoded from the registered index without further delay. The bench drives sof and eol on the falling edge, lets one rising edge pass, and samples every output on the next falling edge. It sweeps every line of a normal frame and of a binned frame against a map computed from the band sizes. In binned mode it also checks, between the two strobes of each output line, that the index has not yet moved.

// File: rtl/lseq_pkg.sv
package lseq_pkg;
  typedef enum logic [2:0] {
    RG_DUMMY    = 3'd0,
    RG_DARK_TOP = 3'd1,
    RG_ISO_TOP  = 3'd2,
    RG_USEFUL   = 3'd3,
    RG_ISO_BOT  = 3'd4,
    RG_DARK_BOT = 3'd5
  } region_e;
endpackage

// File: rtl/lseq_counter.sv
module lseq_counter #(
  parameter int IDX_W    = 11,
  parameter int FULL_LEN = 1056,
  parameter int BIN_LEN  = 544
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic             eol,
  input  logic             binned,
  output logic [IDX_W-1:0] idx,
  output logic             active,
  output logic             bin_q,
  output logic             done,
  output logic             req
);
  localparam logic [IDX_W-1:0] LAST_FULL = IDX_W'(FULL_LEN - 1);
  localparam logic [IDX_W-1:0] LAST_BIN  = IDX_W'(BIN_LEN - 1);

  logic             phase;
  logic             step;
  logic [IDX_W-1:0] last_idx;

  assign last_idx = bin_q ? LAST_BIN : LAST_FULL;
  // an output line completes on every eol, or on every second eol when binned
  assign step = active && eol && (!bin_q || phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= '0;
      active <= 1'b0;
      bin_q  <= 1'b0;
      phase  <= 1'b0;
      done   <= 1'b0;
      req    <= 1'b0;
    end else begin
      done <= 1'b0;
      req  <= 1'b0;
      if (sof) begin
        idx    <= '0;
        active <= 1'b1;
        bin_q  <= binned;
        phase  <= 1'b0;
        req    <= 1'b1;
      end else if (step) begin
        phase <= 1'b0;
        if (idx == last_idx) begin
          idx    <= '0;
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
          req <= 1'b1;
        end
      end else if (active && eol) begin
        phase <= 1'b1;
        req   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lseq_region_map.sv
module lseq_region_map
  import lseq_pkg::*;
#(
  parameter int IDX_W    = 11,
  parameter int DUMMY_N  = 1,
  parameter int DARK_N   = 12,
  parameter int ISO_N    = 3,
  parameter int USEFUL_N = 1024
) (
  input  logic             active,
  input  logic             bin_q,
  input  logic [IDX_W-1:0] idx,
  output region_e          region,
  output logic             first,
  output logic             last
);
  localparam int END_DUMMY = DUMMY_N;
  localparam int END_DARK  = END_DUMMY + DARK_N;
  localparam int END_ISO   = END_DARK + ISO_N;

  logic [IDX_W-1:0] bnd [0:3];

  // band ends after the useful band depend on the useful line count
  for (genvar m = 0; m < 2; m++) begin : g_mode
    localparam int UN = (m == 1) ? USEFUL_N / 2 : USEFUL_N;
    logic [IDX_W-1:0] e_use, e_iso, e_dark, e_last;
    assign e_use  = IDX_W'(END_ISO + UN);
    assign e_iso  = IDX_W'(END_ISO + UN + ISO_N);
    assign e_dark = IDX_W'(END_ISO + UN + ISO_N + DARK_N);
    assign e_last = IDX_W'(END_ISO + UN + ISO_N + DARK_N + DUMMY_N - 1);
  end

  always_comb begin
    if (bin_q) begin
      bnd[0] = g_mode[1].e_use;
      bnd[1] = g_mode[1].e_iso;
      bnd[2] = g_mode[1].e_dark;
      bnd[3] = g_mode[1].e_last;
    end else begin
      bnd[0] = g_mode[0].e_use;
      bnd[1] = g_mode[0].e_iso;
      bnd[2] = g_mode[0].e_dark;
      bnd[3] = g_mode[0].e_last;
    end
  end

  always_comb begin
    if (!active || idx < IDX_W'(END_DUMMY)) region = RG_DUMMY;
    else if (idx < IDX_W'(END_DARK))        region = RG_DARK_TOP;
    else if (idx < IDX_W'(END_ISO))         region = RG_ISO_TOP;
    else if (idx < bnd[0])                  region = RG_USEFUL;
    else if (idx < bnd[1])                  region = RG_ISO_BOT;
    else if (idx < bnd[2])                  region = RG_DARK_BOT;
    else                                    region = RG_DUMMY;
  end

  assign first = active && (idx == '0);
  assign last  = active && (idx == bnd[3]);
endmodule

// File: rtl/line_seq.sv
module line_seq
  import lseq_pkg::*;
#(
  parameter int DUMMY_N  = 1,
  parameter int DARK_N   = 12,
  parameter int ISO_N    = 3,
  parameter int USEFUL_N = 1024,
  localparam int FULL_LEN = 2 * (DUMMY_N + DARK_N + ISO_N) + USEFUL_N,
  localparam int BIN_LEN  = 2 * (DUMMY_N + DARK_N + ISO_N) + USEFUL_N / 2,
  localparam int IDX_W    = $clog2(FULL_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic             eol,
  input  logic             binned,
  output logic [IDX_W-1:0] line_idx,
  output logic [2:0]       region,
  output logic             first_line,
  output logic             last_line,
  output logic             in_frame,
  output logic             frame_done,
  output logic             xfer_req
);
  logic    bin_q;
  region_e rg;

  lseq_counter #(
    .IDX_W(IDX_W), .FULL_LEN(FULL_LEN), .BIN_LEN(BIN_LEN)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .sof(sof), .eol(eol), .binned(binned),
    .idx(line_idx), .active(in_frame), .bin_q(bin_q),
    .done(frame_done), .req(xfer_req)
  );

  lseq_region_map #(
    .IDX_W(IDX_W), .DUMMY_N(DUMMY_N), .DARK_N(DARK_N),
    .ISO_N(ISO_N), .USEFUL_N(USEFUL_N)
  ) u_map (
    .active(in_frame), .bin_q(bin_q), .idx(line_idx),
    .region(rg), .first(first_line), .last(last_line)
  );

  assign region = rg;
endmodule

// File: rtl/lseq_chk.sv
module lseq_chk #(
  parameter int IDX_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sof,
  input logic             eol,
  input logic [IDX_W-1:0] line_idx,
  input logic             first_line,
  input logic             in_frame,
  input logic             frame_done,
  input logic             xfer_req
);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (!in_frame && line_idx == '0));
  // R8
  sof_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> (in_frame && line_idx == '0));
  // R9
  req_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_req && frame_done));
  // R5
  first_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_line |-> (line_idx == '0 && in_frame));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_frame && !sof) |=> (!in_frame && !xfer_req));
  // R3
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && !sof && !eol) |=> $stable(line_idx));
endmodule

bind line_seq lseq_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/test_line_seq.sv
module test_line_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof = 1'b0;
  logic        eol = 1'b0;
  logic        binned = 1'b0;
  logic [10:0] line_idx;
  logic [2:0]  region;
  logic        first_line, last_line, in_frame, frame_done, xfer_req;

  int n_chk = 0;
  int n_bad = 0;

  line_seq i_line_seq (
    .clk(clk), .rst_n(rst_n), .sof(sof), .eol(eol), .binned(binned),
    .line_idx(line_idx), .region(region), .first_line(first_line),
    .last_line(last_line), .in_frame(in_frame), .frame_done(frame_done),
    .xfer_req(xfer_req)
  );

  always #5 clk = ~clk;

  function automatic int exp_region(int l, bit b);
    int u = b ? 512 : 1024;
    if (l < 1) return 0;
    if (l < 13) return 1;
    if (l < 16) return 2;
    if (l < 16 + u) return 3;
    if (l < 19 + u) return 4;
    if (l < 31 + u) return 5;
    return 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at a falling edge, result sampled on the next falling edge
  task automatic pulse(bit s, bit e);
    sof = s; eol = e;
    @(negedge clk);
    sof = 1'b0; eol = 1'b0;
  endtask

  task automatic sweep(bit b);
    int total = b ? 544 : 1056;
    binned = b;
    pulse(1, 0);
    binned = ~b;  // R10: later changes must be ignored
    chk("R2 in_frame", in_frame, 1);
    chk("R2 xfer_req", xfer_req, 1);
    for (int l = 0; l < total; l++) begin
      chk(b ? "R4 idx" : "R3 idx", line_idx, l);
      chk(b ? "R4 region" : "R3 region", region, exp_region(l, b));
      chk("R5 first", first_line, l == 0);
      chk("R5 last", last_line, l == total - 1);
      if (b) begin
        pulse(0, 1);
        chk("R4 idx hold", line_idx, l);
        chk("R9 req half", xfer_req, 1);
      end
      pulse(0, 1);
      if (l < total - 1) chk("R9 req", xfer_req, 1);
    end
    chk("R6 done", frame_done, 1);
    chk("R6 in_frame", in_frame, 0);
    chk("R6 idx", line_idx, 0);
    chk("R9 no req", xfer_req, 0);
    @(negedge clk);
    chk("R6 done once", frame_done, 0);
    binned = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 idx", line_idx, 0);
    chk("R1 region", region, 0);
    chk("R1 flags", {first_line, last_line, in_frame, frame_done, xfer_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: eol while idle
    pulse(0, 1);
    chk("R7 idx", line_idx, 0);
    chk("R7 in_frame", in_frame, 0);
    chk("R7 req", xfer_req, 0);
    chk("R5 idle last", last_line, 0);
    sweep(0);
    sweep(1);
    // R8: restart mid-frame, sof beats eol
    pulse(1, 0);
    for (int k = 0; k < 20; k++) pulse(0, 1);
    chk("R8 pre", line_idx, 20);
    chk("R8 pre region", region, 3);
    pulse(1, 1);
    chk("R8 idx", line_idx, 0);
    chk("R8 first", first_line, 1);
    chk("R8 in_frame", in_frame, 1);
    pulse(0, 1);
    chk("R8 advance", line_idx, 1);
    chk("R8 region", region, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule